// File: doc/BRIEF.md
# Presettable Cascadable Synchronous Counter

A four-bit synchronous up-counter that counts either in decimal (0 to 9) or in plain binary (0 to 15), chosen by a parameter. On each rising clock edge it clears, loads a value from its four data inputs, counts or holds, in that order of priority. A second parameter chooses whether the active-low clear acts at once, independent of the clock, or only at the next rising edge.

Counting needs two active-high enables together: a parallel enable and a trickle enable. A terminal-count output goes high when the counter sits at its top state and the trickle enable is high. Feeding one stage's terminal count into the next stage's trickle enable, with all parallel enables driven by one common signal, builds wider counters with no extra gating. In decimal mode a counter loaded with 10 to 15 finds its way back to the 0 to 9 sequence by itself.

Top module: `dec_bin_counter`

## Requirements
- R1: With DECIMAL=1 the counter counts 0,1,...,9 and then wraps to 0, one step per counting rising edge.
- R2: With DECIMAL=0 the counter counts 0,1,...,15 and then wraps to 0, one step per counting rising edge.
- R3: With ASYNC_CLEAR=0, clr_n low at a rising edge sets q to 0 at that edge, whatever load_n, en_par and en_trk are; q does not change before the edge.
- R4: With ASYNC_CLEAR=1, clr_n low sets q to 0 at once, with no clock edge needed, and holds it at 0 while low.
- R5: With clear inactive, load_n low at a rising edge copies data_in into q, whatever the two enables are.
- R6: With clear inactive and load_n high, q advances only if en_par and en_trk are both high; if either one is low, q holds.
- R7: tc is high exactly when en_trk is high and q is at the top state (9 = 4'b1001 in decimal mode, 15 = 4'b1111 in binary mode); en_par has no effect on tc.
- R8: tc follows a change of en_trk within the same clock cycle, with no clock edge.
- R9: In decimal mode q values 10 to 15 never raise tc, and counting from them goes 10 to 11, 11 to 6, 12 to 13, 13 to 4, 14 to 15, 15 to 2, so the legal range is reached within two counting edges.
- R10: Two stages with the low stage's tc driving the high stage's en_trk and a shared en_par count 0 to 99 (decimal) or 0 to 255 (binary) and then wrap to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Active-low clear, asynchronous or synchronous by parameter |
| load_n | input | 1 | Active-low synchronous load of data_in |
| data_in | input | WIDTH | Value to load |
| en_par | input | 1 | Parallel count enable |
| en_trk | input | 1 | Trickle count enable, also gates tc |
| q | output | WIDTH | Counter state |
| tc | output | 1 | Terminal count |

## Verification
Results of clear, load, count and hold appear on q one rising edge after the inputs that cause them; tc and the asynchronous clear respond within the same cycle. The bench drives every input at the falling edge, queues the value the state must have after the next rising edge, and compares a quarter period after that edge. The same-cycle behaviours are probed one time unit after an input change, well before any edge, so no register can have acted.

// File: rtl/ctr_pkg.sv
`timescale 1ns/1ps
package ctr_pkg;

   typedef enum logic [1:0] {
      MODE_CLEAR = 2'd0,
      MODE_LOAD  = 2'd1,
      MODE_COUNT = 2'd2,
      MODE_HOLD  = 2'd3
   } ctr_mode_e;

endpackage

// File: rtl/ctr_mode_sel.sv
`timescale 1ns/1ps
module ctr_mode_sel
   import ctr_pkg::*;
(
   input  logic      sclr_n,
   input  logic      load_n,
   input  logic      en_par,
   input  logic      en_trk,
   output ctr_mode_e mode
);

   always_comb begin
      if (!sclr_n)
         mode = MODE_CLEAR;
      else if (!load_n)
         mode = MODE_LOAD;
      else if (en_par && en_trk)
         mode = MODE_COUNT;
      else
         mode = MODE_HOLD;
   end

endmodule

// File: rtl/ctr_next.sv
`timescale 1ns/1ps
module ctr_next
   import ctr_pkg::*;
#(
   parameter int unsigned WIDTH   = 4,
   parameter bit          DECIMAL = 1'b1
) (
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] data_in,
   input  ctr_mode_e        mode,
   output logic [WIDTH-1:0] nxt
);

   logic [WIDTH-1:0] stepped;

   generate
      if (DECIMAL) begin : g_dec
         logic [3:0] flip;
         always_comb begin
            flip[0] = 1'b1;
            flip[1] = cur[0] & ~cur[3];
            flip[2] = cur[0] & cur[1];
            flip[3] = (cur[0] & cur[1] & cur[2]) | (cur[0] & cur[3]);
         end
         assign stepped = cur ^ flip;
      end else begin : g_bin
         assign stepped = cur + WIDTH'(1);
      end
   endgenerate

   always_comb begin
      unique case (mode)
         MODE_CLEAR: nxt = '0;
         MODE_LOAD:  nxt = data_in;
         MODE_COUNT: nxt = stepped;
         default:    nxt = cur;
      endcase
   end

endmodule

// File: rtl/ctr_state_reg.sv
`timescale 1ns/1ps
module ctr_state_reg #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [WIDTH-1:0] nxt,
   output logic [WIDTH-1:0] cur
);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)
         cur <= '0;
      else
         cur <= nxt;
   end

endmodule

// File: rtl/ctr_tc_decode.sv
`timescale 1ns/1ps
module ctr_tc_decode #(
   parameter int unsigned WIDTH   = 4,
   parameter bit          DECIMAL = 1'b1
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             en_trk,
   output logic             tc
);

   localparam logic [WIDTH-1:0] TOP = DECIMAL ? WIDTH'(9) : {WIDTH{1'b1}};

   assign tc = en_trk & (cur == TOP);

endmodule

// File: rtl/dec_bin_counter.sv
`timescale 1ns/1ps
module dec_bin_counter
   import ctr_pkg::*;
#(
   parameter int unsigned WIDTH       = 4,
   parameter bit          DECIMAL     = 1'b1,
   parameter bit          ASYNC_CLEAR = 1'b0
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             load_n,
   input  logic [WIDTH-1:0] data_in,
   input  logic             en_par,
   input  logic             en_trk,
   output logic [WIDTH-1:0] q,
   output logic             tc
);

   generate
      if (DECIMAL && WIDTH != 4) begin : g_bad_dec
         $error("dec_bin_counter: decimal mode needs WIDTH of 4");
      end
      if (WIDTH < 2) begin : g_bad_width
         $error("dec_bin_counter: WIDTH must be at least 2");
      end
   endgenerate

   logic             sclr_n;
   logic             arst_n;
   ctr_mode_e        mode;
   logic [WIDTH-1:0] nxt;

   generate
      if (ASYNC_CLEAR) begin : g_aclr
         assign arst_n = clr_n;
         assign sclr_n = 1'b1;
      end else begin : g_sclr
         assign arst_n = 1'b1;
         assign sclr_n = clr_n;
      end
   endgenerate

   ctr_mode_sel u_mode (
      .sclr_n (sclr_n),
      .load_n (load_n),
      .en_par (en_par),
      .en_trk (en_trk),
      .mode   (mode)
   );

   ctr_next #(.WIDTH(WIDTH), .DECIMAL(DECIMAL)) u_next (
      .cur     (q),
      .data_in (data_in),
      .mode    (mode),
      .nxt     (nxt)
   );

   ctr_state_reg #(.WIDTH(WIDTH)) u_reg (
      .clk    (clk),
      .arst_n (arst_n),
      .nxt    (nxt),
      .cur    (q)
   );

   ctr_tc_decode #(.WIDTH(WIDTH), .DECIMAL(DECIMAL)) u_tc (
      .cur    (q),
      .en_trk (en_trk),
      .tc     (tc)
   );

endmodule

// File: rtl/ctr_checker.sv
`timescale 1ns/1ps
module ctr_checker #(
   parameter int unsigned WIDTH       = 4,
   parameter bit          DECIMAL     = 1'b1,
   parameter bit          ASYNC_CLEAR = 1'b0
) (
   input logic             clk,
   input logic             clr_n,
   input logic             load_n,
   input logic [WIDTH-1:0] data_in,
   input logic             en_par,
   input logic             en_trk,
   input logic [WIDTH-1:0] q,
   input logic             tc
);

   localparam logic [WIDTH-1:0] TOP = DECIMAL ? WIDTH'(9) : {WIDTH{1'b1}};

   generate
      if (ASYNC_CLEAR) begin : g_a
         p_async_clear_r4: assert property (@(posedge clk)
            !clr_n |-> q == '0);
      end else begin : g_s
         p_sync_clear_r3: assert property (@(posedge clk)
            !clr_n |=> q == '0);
      end
   endgenerate

   p_load_r5: assert property (@(posedge clk) disable iff (!clr_n)
      !load_n |=> q == $past(data_in));

   p_hold_r6: assert property (@(posedge clk) disable iff (!clr_n)
      load_n && !(en_par && en_trk) |=> $stable(q));

   p_tc_trk_r7: assert property (@(posedge clk) disable iff (!clr_n)
      !en_trk |-> !tc);

   p_tc_top_r7: assert property (@(posedge clk) disable iff (!clr_n)
      tc |-> q == TOP);

   generate
      if (DECIMAL) begin : g_d
         p_wrap_r1: assert property (@(posedge clk) disable iff (!clr_n)
            load_n && en_par && en_trk && q == TOP |=> q == '0);
         p_no_tc_illegal_r9: assert property (@(posedge clk) disable iff (!clr_n)
            q > WIDTH'(9) |-> !tc);
         p_stay_legal_r9: assert property (@(posedge clk) disable iff (!clr_n)
            load_n && q <= WIDTH'(9) |=> q <= WIDTH'(9));
      end else begin : g_b
         p_wrap_r2: assert property (@(posedge clk) disable iff (!clr_n)
            load_n && en_par && en_trk && q == TOP |=> q == '0);
      end
   endgenerate

endmodule

bind dec_bin_counter ctr_checker #(
   .WIDTH(WIDTH), .DECIMAL(DECIMAL), .ASYNC_CLEAR(ASYNC_CLEAR)
) chk_i (
   .clk(clk), .clr_n(clr_n), .load_n(load_n), .data_in(data_in),
   .en_par(en_par), .en_trk(en_trk), .q(q), .tc(tc)
);

// File: tb/dec_bin_counter_tb.sv
`timescale 1ns/1ps
module dec_bin_counter_tb_top;

   localparam int CLK_P = 10;

   typedef struct {
      int    qi;
      int    tci;
      int    qa;
      int    tca;
      int    cb;
      int    cn;
      string tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       clr_n_s = 1'b0;
   logic       load_n_s = 1'b1;
   logic [3:0] data_s = 4'd0;
   logic       en_par_s = 1'b0;
   logic       en_trk_s = 1'b0;
   logic       cclr_n_s = 1'b0;
   logic       cen_s = 1'b0;

   logic [3:0] q_i, q_a, bl_q, bh_q, nl_q, nh_q;
   logic       tc_i, tc_a, bl_tc, bh_tc, nl_tc, nh_tc;

   int checks = 0;
   int errors = 0;
   int mdl_i = 0, mdl_a = 0, mdl_cb = 0, mdl_cn = 0;
   exp_t sb[$];

   always #(CLK_P/2) clk = ~clk;

   // decimal, synchronous clear
   dec_bin_counter #(.WIDTH(4), .DECIMAL(1'b1), .ASYNC_CLEAR(1'b0)) dut_i (
      .clk(clk), .clr_n(clr_n_s), .load_n(load_n_s), .data_in(data_s),
      .en_par(en_par_s), .en_trk(en_trk_s), .q(q_i), .tc(tc_i));

   // binary, asynchronous clear
   dec_bin_counter #(.WIDTH(4), .DECIMAL(1'b0), .ASYNC_CLEAR(1'b1)) dut_a (
      .clk(clk), .clr_n(clr_n_s), .load_n(load_n_s), .data_in(data_s),
      .en_par(en_par_s), .en_trk(en_trk_s), .q(q_a), .tc(tc_a));

   // two-stage decimal chain (asynchronous clear)
   dec_bin_counter #(.WIDTH(4), .DECIMAL(1'b1), .ASYNC_CLEAR(1'b1)) dec_lo (
      .clk(clk), .clr_n(cclr_n_s), .load_n(1'b1), .data_in(4'd0),
      .en_par(cen_s), .en_trk(1'b1), .q(bl_q), .tc(bl_tc));
   dec_bin_counter #(.WIDTH(4), .DECIMAL(1'b1), .ASYNC_CLEAR(1'b1)) dec_hi (
      .clk(clk), .clr_n(cclr_n_s), .load_n(1'b1), .data_in(4'd0),
      .en_par(cen_s), .en_trk(bl_tc), .q(bh_q), .tc(bh_tc));

   // two-stage binary chain (synchronous clear)
   dec_bin_counter #(.WIDTH(4), .DECIMAL(1'b0), .ASYNC_CLEAR(1'b0)) bin_lo (
      .clk(clk), .clr_n(cclr_n_s), .load_n(1'b1), .data_in(4'd0),
      .en_par(cen_s), .en_trk(1'b1), .q(nl_q), .tc(nl_tc));
   dec_bin_counter #(.WIDTH(4), .DECIMAL(1'b0), .ASYNC_CLEAR(1'b0)) bin_hi (
      .clk(clk), .clr_n(cclr_n_s), .load_n(1'b1), .data_in(4'd0),
      .en_par(cen_s), .en_trk(nl_tc), .q(nh_q), .tc(nh_tc));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // decimal step from requirements R1 and R9
   function automatic int dec_step(input int v);
      case (v)
         9:       return 0;
         10:      return 11;
         11:      return 6;
         12:      return 13;
         13:      return 4;
         14:      return 15;
         15:      return 2;
         default: return v + 1;
      endcase
   endfunction

   function automatic int model(input int v, input logic c, input logic l,
                                input logic [3:0] d, input logic ep, input logic et,
                                input bit dec);
      if (!c)            return 0;
      else if (!l)       return int'(d);
      else if (ep && et) return dec ? dec_step(v) : (v + 1) % 16;
      else               return v;
   endfunction

   task automatic step(input logic c, input logic l, input logic [3:0] d,
                       input logic ep, input logic et, input logic cc,
                       input logic ce, input string tag);
      exp_t e;
      @(negedge clk);
      clr_n_s = c; load_n_s = l; data_s = d; en_par_s = ep; en_trk_s = et;
      cclr_n_s = cc; cen_s = ce;
      mdl_i  = model(mdl_i, c, l, d, ep, et, 1'b1);
      mdl_a  = model(mdl_a, c, l, d, ep, et, 1'b0);
      mdl_cb = !cc ? 0 : (ce ? (mdl_cb + 1) % 100 : mdl_cb);
      mdl_cn = !cc ? 0 : (ce ? (mdl_cn + 1) % 256 : mdl_cn);
      e.qi = mdl_i;  e.tci = (et && mdl_i == 9)  ? 1 : 0;
      e.qa = mdl_a;  e.tca = (et && mdl_a == 15) ? 1 : 0;
      e.cb = mdl_cb; e.cn = mdl_cn; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic drain();
      wait (sb.size() == 0);
      #1;
   endtask

   // monitor: compares a quarter period after each rising edge
   always @(posedge clk) begin
      #(CLK_P/4);
      if (sb.size() > 0) begin
         exp_t e;
         int   cb_act, cn_act;
         e = sb.pop_front();
         cb_act = int'(bh_q) * 10 + int'(bl_q);
         cn_act = int'(nh_q) * 16 + int'(nl_q);
         chk(int'(q_i) == e.qi,   {e.tag, " q dec"},  int'(q_i),  e.qi);
         chk(int'(tc_i) == e.tci, {e.tag, " tc dec"}, int'(tc_i), e.tci);
         chk(int'(q_a) == e.qa,   {e.tag, " q bin"},  int'(q_a),  e.qa);
         chk(int'(tc_a) == e.tca, {e.tag, " tc bin"}, int'(tc_a), e.tca);
         chk(cb_act == e.cb, {e.tag, " R10 dec chain"}, cb_act, e.cb);
         chk(cn_act == e.cn, {e.tag, " R10 bin chain"}, cn_act, e.cn);
      end
   end

   initial begin
      #(CLK_P * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R3 reset state through synchronous and asynchronous clear
      step(1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 R4 reset");
      step(1'b0, 1'b0, 4'd6, 1'b1, 1'b1, 1'b0, 1'b0, "R3 clear over load");

      // R1 R2 R7 plain counting across both wraps
      for (int k = 0; k < 20; k++)
         step(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R1 R2 R7 count");

      // R6 hold via each enable alone; R7 tc with trickle low
      step(1'b1, 1'b1, 4'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R6 hold en_par low");
      step(1'b1, 1'b1, 4'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R6 hold en_par low");
      step(1'b1, 1'b1, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0, "R6 R7 hold en_trk low");
      step(1'b1, 1'b1, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0, "R6 R7 hold en_trk low");

      // R5 load with enables off, and load during count
      step(1'b1, 1'b0, 4'd5, 1'b0, 1'b0, 1'b1, 1'b0, "R5 load idle");
      step(1'b1, 1'b0, 4'd9, 1'b1, 1'b1, 1'b1, 1'b0, "R5 load while counting");
      step(1'b1, 1'b1, 4'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R7 tc at top, en_par low");
      step(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R1 wrap after load");
      step(1'b1, 1'b0, 4'd15, 1'b0, 1'b1, 1'b1, 1'b0, "R5 R7 load 15");

      // R3 clear during load
      step(1'b0, 1'b0, 4'd7, 1'b1, 1'b1, 1'b1, 1'b0, "R3 clear during load");

      // R9 recovery from each illegal decimal code
      for (int c = 10; c < 16; c++) begin
         step(1'b1, 1'b0, 4'(c), 1'b1, 1'b1, 1'b1, 1'b0, "R9 load illegal");
         step(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R9 first count");
         step(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R9 second count");
      end

      // R8 tc follows en_trk without a clock edge
      step(1'b1, 1'b0, 4'd9, 1'b0, 1'b1, 1'b1, 1'b0, "R8 setup");
      drain();
      @(negedge clk);
      en_trk_s = 1'b0;
      #1 chk(tc_i == 1'b0, "R8 tc drops with en_trk", int'(tc_i), 0);
      en_trk_s = 1'b1;
      #1 chk(tc_i == 1'b1, "R8 tc rises with en_trk", int'(tc_i), 1);

      // R4 immediate clear versus R3 edge clear
      step(1'b1, 1'b0, 4'd7, 1'b0, 1'b0, 1'b1, 1'b0, "R4 setup");
      drain();
      @(negedge clk);
      clr_n_s = 1'b0;
      #1;
      chk(q_a == 4'd0, "R4 async clear without edge", int'(q_a), 0);
      chk(q_i == 4'd7, "R3 sync clear waits for edge", int'(q_i), 7);
      @(posedge clk);
      #2 chk(q_i == 4'd0, "R3 sync clear at edge", int'(q_i), 0);
      mdl_i = 0;
      mdl_a = 0;

      // R10 cascaded chains through both wraps
      step(1'b1, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 chain clear");
      for (int k = 0; k < 260; k++)
         step(1'b1, 1'b1, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1, "R10 chain count");
      drain();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule